// File: doc/BRIEF.md
# Dual-Identity Byte-Register Target for a Two-Wire Serial Bus

This block is the target side of an I2C bus. It answers to two 7-bit device identifiers. Each identifier opens its own 256-byte address space: a control/status space and a general-purpose memory space. Each space is served by a plain synchronous register-file port. A strobe and an address leave the block; for reads, the data comes back on the following clock.

SCL and SDA arrive already synchronized to the system clock. The block registers them once more and detects clock edges, start conditions and stop conditions from those samples. It drives SDA only through an open-drain enable, where a high enable pulls the line low. A single word-address counter, cleared by reset, is shared by both spaces. A write loads it from the word-address byte. Every data byte written or fetched advances it, so current-address reads and random reads both work.

The control state machine has ten states:
- `ST_IDLE`: waiting after reset or after a stop.
- `ST_ADDR_RX`: shifting in the slave byte.
- `ST_ADDR_ACK`: acknowledging the slave byte.
- `ST_WORD_RX` and `ST_WORD_ACK`: receiving and acknowledging the word address.
- `ST_DATA_RX` and `ST_DATA_ACK`: receiving and acknowledging write data.
- `ST_TX_BYTE`: shifting out read data.
- `ST_TX_ACK`: sampling the master's acknowledge.
- `ST_PARK`: deaf until the next start.

The transitions are:
- A stop from any state goes to `ST_IDLE`.
- A start or repeated start from any state goes to `ST_ADDR_RX`.
- At the SCL fall that ends the eighth bit, `ST_ADDR_RX` goes to `ST_ADDR_ACK` on an accepted identifier and to `ST_PARK` otherwise.
- At the end of `ST_ADDR_ACK`, a read goes to `ST_TX_BYTE` and a write goes to `ST_WORD_RX`.
- `ST_WORD_RX` goes to `ST_WORD_ACK`, then to `ST_DATA_RX`.
- `ST_DATA_RX` goes to `ST_DATA_ACK`, then back to `ST_DATA_RX`.
- `ST_TX_BYTE` goes to `ST_TX_ACK` after eight bits.
- `ST_TX_ACK` goes back to `ST_TX_BYTE` on an acknowledge and to `ST_PARK` on a not-acknowledge.

Top module: `i2c_dual_target`

## Requirements
- R1: A falling SDA while SCL is high (start) sends the block to slave-byte reception from any state and discards a partly received byte. A rising SDA while SCL is high (stop) returns it to idle with SDA released.
- R2: The slave byte is received MSB first: seven identifier bits, then the direction bit (1 = read, 0 = write). Identifier 7'h6F selects the control/status port (`csr_*`) and identifier 7'h57 selects the memory port (`mem_*`).
- R3: On a matching slave byte, `sda_oe` is high from the SCL fall ending bit 8 to the SCL fall ending bit 9. For any other identifier, `sda_oe` stays low and neither port is strobed until the next start.
- R4: In a write, the byte after the slave byte loads the word-address counter and is acknowledged. Each following byte is acknowledged and produces one single-cycle write strobe on the selected port, with address equal to the counter and data equal to the byte. The counter then advances by one.
- R5: The counter is 0 after reset, so a current-address read issued first returns location 0.
- R6: Read data is sent MSB first. Each bit changes only after an SCL fall and is stable while SCL is high. `sda_oe` high means a 0 bit. One fetch strobe is issued per byte, and each fetch advances the counter.
- R7: A master acknowledge (SDA low on the ninth clock) makes the block send the next byte. A not-acknowledge releases SDA until the next start or stop.
- R8: A random read returns data from the address given in its dummy write. A repeated-start read whose identifier differs from the dummy write's identifier is not acknowledged and is ignored, but the counter keeps the loaded address.
- R9: The counter wraps from 8'hFF to 8'h00.
- R10: Only the port of the selected space is strobed; the other port sees no write or read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| csr_we | output | 1 | Control/status write strobe |
| csr_re | output | 1 | Control/status fetch strobe |
| csr_addr | output | 8 | Control/status address (word-address counter) |
| csr_wdata | output | 8 | Control/status write data |
| csr_rdata | input | 8 | Control/status read data, valid the cycle after `csr_re` |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory fetch strobe |
| mem_addr | output | 8 | Memory address (word-address counter) |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_re` |

## Verification
The bench builds the block with its default identifiers, 7'h6F and 7'h57, and runs SCL at sixteen system clocks per bit. With that SCL rate, the two-cycle input pipeline and the one-cycle read latency both fit inside a half bit. Because the word address is only one byte, the FF-to-00 wrap is reached by a three-byte burst starting at FE. Mixing the two identifiers in one dummy-write/read pair exercises both the shared counter and the identifier-clash refusal.

// File: rtl/i2c_dual_pkg.sv
`timescale 1ns/1ps
package i2c_dual_pkg;
    localparam int BYTE_W   = 8;
    localparam int ID_W     = BYTE_W - 1;
    localparam int BITCNT_W = 4;
    localparam int NSPACE   = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR_RX,
        ST_ADDR_ACK,
        ST_WORD_RX,
        ST_WORD_ACK,
        ST_DATA_RX,
        ST_DATA_ACK,
        ST_TX_BYTE,
        ST_TX_ACK,
        ST_PARK
    } tgt_state_e;

    typedef enum logic [0:0] {
        SPC_CSR = 1'b0,
        SPC_MEM = 1'b1
    } space_e;
endpackage

// File: rtl/i2c_dual_cond.sv
`timescale 1ns/1ps
module i2c_dual_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop,
    output logic sda_s
);
    logic scl_a, scl_b, sda_a, sda_b;

    // Idle bus is high on both lines, so reset to 1 to avoid a false edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_a <= 1'b1;
            scl_b <= 1'b1;
            sda_a <= 1'b1;
            sda_b <= 1'b1;
        end else begin
            scl_a <= scl_i;
            scl_b <= scl_a;
            sda_a <= sda_i;
            sda_b <= sda_a;
        end
    end

    assign scl_rise  = scl_a & ~scl_b;
    assign scl_fall  = ~scl_a & scl_b;
    assign bus_start = scl_a & scl_b & sda_b & ~sda_a;
    assign bus_stop  = scl_a & scl_b & ~sda_b & sda_a;
    assign sda_s     = sda_a;
endmodule

// File: rtl/i2c_dual_wcnt.sv
`timescale 1ns/1ps
module i2c_dual_wcnt #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (inc)  cnt_q <= cnt_q + 1'b1;
    end

    assign addr = cnt_q;

    // R9
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && cnt_q == '1) |=> cnt_q == '0);

    // R4
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));
endmodule

// File: rtl/i2c_dual_fsm.sv
`timescale 1ns/1ps
module i2c_dual_fsm
    import i2c_dual_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_CSR = 7'h6F,
    parameter logic [ID_W-1:0] ID_MEM = 7'h57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              sda_s,
    input  logic [BYTE_W-1:0] rdata,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic              rd_stb,
    output space_e            space,
    output logic [BYTE_W-1:0] wdata,
    output logic              cnt_load,
    output logic [BYTE_W-1:0] load_val
);
    tgt_state_e          state_q, state_d;
    logic [BITCNT_W-1:0] bit_q;
    logic [BYTE_W-1:0]   rx_q, tx_q;
    logic                rd_q, rw_q, bind_vld_q;
    space_e              space_q, bind_q, hit_spc;
    logic [ID_W-1:0]     id_w;
    logic                rw_w, hit_csr, hit_mem, clash, accept, byte_in, quiet, rx_state;

    assign id_w     = rx_q[BYTE_W-1:1];
    assign rw_w     = rx_q[0];
    assign hit_csr  = (id_w == ID_CSR);
    assign hit_mem  = (id_w == ID_MEM);
    assign hit_spc  = hit_mem ? SPC_MEM : SPC_CSR;
    assign clash    = rw_w && bind_vld_q && (hit_spc != bind_q);
    assign accept   = (hit_csr || hit_mem) && !clash;
    assign byte_in  = scl_fall && (bit_q == BITCNT_W'(BYTE_W));
    assign quiet    = !bus_start && !bus_stop;
    assign rx_state = (state_q == ST_ADDR_RX) || (state_q == ST_WORD_RX) ||
                      (state_q == ST_DATA_RX);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (bus_stop) begin
            state_d = ST_IDLE;
        end else if (bus_start) begin
            state_d = ST_ADDR_RX;
        end else begin
            unique case (state_q)
                ST_ADDR_RX:  if (byte_in)  state_d = accept ? ST_ADDR_ACK : ST_PARK;
                ST_ADDR_ACK: if (scl_fall) state_d = rw_q ? ST_TX_BYTE : ST_WORD_RX;
                ST_WORD_RX:  if (byte_in)  state_d = ST_WORD_ACK;
                ST_WORD_ACK: if (scl_fall) state_d = ST_DATA_RX;
                ST_DATA_RX:  if (byte_in)  state_d = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) state_d = ST_DATA_RX;
                ST_TX_BYTE:  if (scl_fall && bit_q == BITCNT_W'(BYTE_W - 1))
                                 state_d = ST_TX_ACK;
                ST_TX_ACK: begin
                    if (scl_rise && sda_s) state_d = ST_PARK;
                    else if (scl_fall)     state_d = ST_TX_BYTE;
                end
                ST_IDLE, ST_PARK: state_d = state_q;
                default:          state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Shifters, bit counter and identity binding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q      <= '0;
            rx_q       <= '0;
            tx_q       <= '1;
            rd_q       <= 1'b0;
            rw_q       <= 1'b0;
            space_q    <= SPC_CSR;
            bind_q     <= SPC_CSR;
            bind_vld_q <= 1'b0;
        end else begin
            rd_q <= rd_stb;
            if (state_d != state_q || bus_start)
                bit_q <= '0;
            else if (rx_state && scl_rise)
                bit_q <= bit_q + 1'b1;
            else if (state_q == ST_TX_BYTE && scl_fall)
                bit_q <= bit_q + 1'b1;

            if (rx_state && scl_rise)
                rx_q <= {rx_q[BYTE_W-2:0], sda_s};

            if (rd_q)
                tx_q <= rdata;
            else if (state_q == ST_TX_BYTE && scl_fall)
                tx_q <= {tx_q[BYTE_W-2:0], 1'b1};

            if (bus_stop) begin
                bind_vld_q <= 1'b0;
            end else if (state_q == ST_ADDR_RX && byte_in && quiet && accept) begin
                space_q <= hit_spc;
                rw_q    <= rw_w;
                if (!rw_w) begin
                    bind_vld_q <= 1'b1;
                    bind_q     <= hit_spc;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        sda_oe   = 1'b0;
        wr_stb   = 1'b0;
        rd_stb   = 1'b0;
        cnt_load = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK, ST_WORD_ACK, ST_DATA_ACK: sda_oe = 1'b1;
            ST_TX_BYTE: sda_oe   = ~tx_q[BYTE_W-1];
            ST_ADDR_RX: rd_stb   = quiet && byte_in && accept && rw_w;
            ST_WORD_RX: cnt_load = quiet && byte_in;
            ST_DATA_RX: wr_stb   = quiet && byte_in;
            ST_TX_ACK:  rd_stb   = quiet && scl_rise && !sda_s;
            default: ;
        endcase
    end

    assign space    = (state_q == ST_ADDR_RX) ? hit_spc : space_q;
    assign wdata    = rx_q;
    assign load_val = rx_q;

    // R1
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> state_q == ST_IDLE);

    // R1
    start_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> state_q == ST_ADDR_RX);

    // R6
    oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R4
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R8
    clash_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_RX && byte_in && quiet && clash) |=> state_q == ST_PARK);
endmodule

// File: rtl/i2c_dual_route.sv
`timescale 1ns/1ps
module i2c_dual_route
    import i2c_dual_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_stb,
    input  logic                          rd_stb,
    input  space_e                        space,
    input  logic [NSPACE-1:0][BYTE_W-1:0] rdata_v,
    output logic [NSPACE-1:0]             we_v,
    output logic [NSPACE-1:0]             re_v,
    output logic [BYTE_W-1:0]             rdata
);
    for (genvar g = 0; g < NSPACE; g++) begin : g_spc
        assign we_v[g] = wr_stb && (int'(space) == g);
        assign re_v[g] = rd_stb && (int'(space) == g);
    end

    assign rdata = rdata_v[space];

    // R10
    port_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we_v, re_v}));
endmodule

// File: rtl/i2c_dual_target.sv
`timescale 1ns/1ps
module i2c_dual_target
    import i2c_dual_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_CSR = 7'h6F,
    parameter logic [ID_W-1:0] ID_MEM = 7'h57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              csr_we,
    output logic              csr_re,
    output logic [BYTE_W-1:0] csr_addr,
    output logic [BYTE_W-1:0] csr_wdata,
    input  logic [BYTE_W-1:0] csr_rdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [BYTE_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata
);
    logic scl_rise, scl_fall, bus_start, bus_stop, sda_s;
    logic wr_stb, rd_stb, cnt_load;
    logic [BYTE_W-1:0] wdata, load_val, rdata, addr;
    space_e space;
    logic [NSPACE-1:0] we_v, re_v;
    logic [NSPACE-1:0][BYTE_W-1:0] rdata_v;

    i2c_dual_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop), .sda_s(sda_s)
    );

    i2c_dual_fsm #(.ID_CSR(ID_CSR), .ID_MEM(ID_MEM)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop), .sda_s(sda_s),
        .rdata(rdata), .sda_oe(sda_oe), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .space(space), .wdata(wdata), .cnt_load(cnt_load), .load_val(load_val)
    );

    i2c_dual_wcnt #(.AW(BYTE_W)) u_wcnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(load_val),
        .inc(wr_stb | rd_stb), .addr(addr)
    );

    assign rdata_v[SPC_CSR] = csr_rdata;
    assign rdata_v[SPC_MEM] = mem_rdata;

    i2c_dual_route u_route (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .space(space), .rdata_v(rdata_v), .we_v(we_v), .re_v(re_v), .rdata(rdata)
    );

    assign csr_we    = we_v[SPC_CSR];
    assign csr_re    = re_v[SPC_CSR];
    assign mem_we    = we_v[SPC_MEM];
    assign mem_re    = re_v[SPC_MEM];
    assign csr_addr  = addr;
    assign mem_addr  = addr;
    assign csr_wdata = wdata;
    assign mem_wdata = wdata;
endmodule

// File: tb/i2c_dual_target_bench.sv
`timescale 1ns/1ps
module i2c_dual_target_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, csr_we, csr_re, mem_we, mem_re;
    logic [7:0] csr_addr, csr_wdata, csr_rdata, mem_addr, mem_wdata, mem_rdata;
    logic sda_line;
    logic [7:0] csr_model [256];
    logic [7:0] mem_model [256];
    logic [7:0] csr_exp [256];
    logic [7:0] mem_exp [256];
    logic [7:0] exp_ptr;
    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2c_dual_target u_i2c_dual_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .csr_we(csr_we), .csr_re(csr_re), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Register-file back ends: one-cycle read latency
    always @(posedge clk) begin
        if (csr_we) csr_model[csr_addr] <= csr_wdata;
        if (csr_re) csr_rdata <= csr_model[csr_addr];
        if (mem_we) mem_model[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem_model[mem_addr];
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] slave_byte(input bit spc, input bit rd);
        return {(spc ? 7'h57 : 7'h6F), rd};
    endfunction

    function automatic logic [7:0] exp_at(input bit spc, input logic [7:0] a);
        return spc ? mem_exp[a] : csr_exp[a];
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl = 1'b1; tick(4); sda_m = 1'b0; tick(4); scl = 1'b0; tick(4);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(4); scl = 1'b1; tick(4); sda_m = 1'b0; tick(4); scl = 1'b0; tick(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(4); scl = 1'b1; tick(4); sda_m = 1'b1; tick(4);
        check(sda_oe == 1'b0, "R1 SDA released after stop", sda_oe, 0);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(4); scl = 1'b1; tick(8); scl = 1'b0; tick(4);
    endtask

    task automatic recv_bit(output logic b);
        logic b2;
        sda_m = 1'b1; tick(4); scl = 1'b1; tick(2); b = sda_line;
        tick(5); b2 = sda_line; tick(1); scl = 1'b0; tick(4);
        check(b == b2, "R6 SDA stable while SCL high", b2, b);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack_n);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(ack_n);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] v);
        logic bt;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            recv_bit(bt);
            v = {v[6:0], bt};
        end
        send_bit(nack);
    endtask

    task automatic do_write(input bit spc, input logic [7:0] a, input int n);
        logic ack_n;
        logic [7:0] d;
        bus_start();
        send_byte(slave_byte(spc, 1'b0), ack_n);
        check(ack_n == 1'b0, "R2/R3 write slave byte acknowledged", ack_n, 0);
        send_byte(a, ack_n);
        check(ack_n == 1'b0, "R4 word address acknowledged", ack_n, 0);
        exp_ptr = a;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            send_byte(d, ack_n);
            check(ack_n == 1'b0, "R4 data byte acknowledged", ack_n, 0);
            if (spc) mem_exp[exp_ptr] = d; else csr_exp[exp_ptr] = d;
            exp_ptr = exp_ptr + 8'd1;
        end
        bus_stop();
    endtask

    task automatic read_bytes(input bit spc, input int n);
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, v);
            check(v == exp_at(spc, exp_ptr), "R6/R7 read data", v, exp_at(spc, exp_ptr));
            exp_ptr = exp_ptr + 8'd1;
        end
    endtask

    task automatic do_rread(input bit spc, input logic [7:0] a, input int n);
        logic ack_n;
        bus_start();
        send_byte(slave_byte(spc, 1'b0), ack_n);
        check(ack_n == 1'b0, "R8 dummy write acknowledged", ack_n, 0);
        send_byte(a, ack_n);
        check(ack_n == 1'b0, "R8 word address acknowledged", ack_n, 0);
        exp_ptr = a;
        bus_rstart();
        send_byte(slave_byte(spc, 1'b1), ack_n);
        check(ack_n == 1'b0, "R8 read slave byte acknowledged", ack_n, 0);
        read_bytes(spc, n);
        bus_stop();
    endtask

    task automatic do_cread(input bit spc, input int n);
        logic ack_n;
        bus_start();
        send_byte(slave_byte(spc, 1'b1), ack_n);
        check(ack_n == 1'b0, "R2 current read acknowledged", ack_n, 0);
        read_bytes(spc, n);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic ack_n;
        logic [7:0] v;
        int bad;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin
            csr_model[i] = 8'(i) ^ 8'hA5;
            csr_exp[i]   = 8'(i) ^ 8'hA5;
            mem_model[i] = 8'(i * 3 + 1);
            mem_exp[i]   = 8'(i * 3 + 1);
        end
        csr_rdata = '0;
        mem_rdata = '0;
        exp_ptr = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        check(sda_oe == 1'b0, "R1 reset SDA released", sda_oe, 0);
        check({csr_we, csr_re, mem_we, mem_re} == 4'b0, "R10 reset no strobes",
              {csr_we, csr_re, mem_we, mem_re}, 0);

        // R5: first current read returns location 0
        do_cread(1'b0, 1);

        // R3: unknown identifier is ignored until next start
        bus_start();
        send_byte(8'h42, ack_n);
        check(ack_n == 1'b1, "R3 unknown identifier not acknowledged", ack_n, 1);
        send_byte(8'h00, ack_n);
        check(ack_n == 1'b1, "R3 ignored byte not acknowledged", ack_n, 1);
        send_byte(8'h5A, ack_n);
        check(ack_n == 1'b1, "R3 ignored data not acknowledged", ack_n, 1);
        bus_stop();

        // R1: start mid-byte abandons the partial byte
        bus_start();
        send_byte(slave_byte(1'b0, 1'b0), ack_n);
        send_byte(8'h20, ack_n);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_rstart();
        send_byte(slave_byte(1'b0, 1'b0), ack_n);
        check(ack_n == 1'b0, "R1 slave byte after interrupting start", ack_n, 0);
        send_byte(8'h21, ack_n);
        send_byte(8'h3C, ack_n);
        csr_exp[8'h21] = 8'h3C;
        exp_ptr = 8'h22;
        bus_stop();
        do_rread(1'b0, 8'h20, 2);

        // R9: wrap FF -> 00
        do_write(1'b1, 8'hFE, 3);
        do_rread(1'b1, 8'hFE, 3);
        do_cread(1'b1, 1);

        // R8: identifier clash on repeated-start read
        bus_start();
        send_byte(slave_byte(1'b0, 1'b0), ack_n);
        send_byte(8'h10, ack_n);
        exp_ptr = 8'h10;
        bus_rstart();
        send_byte(slave_byte(1'b1, 1'b1), ack_n);
        check(ack_n == 1'b1, "R8 clashing read identifier not acknowledged", ack_n, 1);
        recv_byte(1'b1, v);
        check(v == 8'hFF, "R8 clashing read leaves SDA released", v, 8'hFF);
        bus_stop();
        do_cread(1'b1, 2);

        // Constrained random mix
        for (int t = 0; t < 30; t++) begin
            int op;
            bit spc;
            logic [7:0] a;
            int n;
            op  = int'($urandom % 3);
            spc = 1'($urandom);
            a   = 8'($urandom);
            n   = 1 + int'($urandom % 4);
            case (op)
                0:       do_write(spc, a, n);
                1:       do_rread(spc, a, n);
                default: do_cread(spc, n);
            endcase
        end

        // R10 / R4: back-end contents match expectation
        tick(4);
        bad = 0;
        for (int i = 0; i < 256; i++) begin
            if (csr_model[i] != csr_exp[i]) bad++;
            if (mem_model[i] != mem_exp[i]) bad++;
        end
        check(bad == 0, "R10 only the selected space was written", bad, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule